// File: doc/BRIEF.md
# Distributed Bus Ownership Arbiter

Each processor on a shared external bus has one copy of this block, and no central arbiter exists. Up to eight agents share the bus. An agent pulls low the one active-low request line that its identity number selects. It watches the sampled state of all eight lines, and from them it works out which agent owns the bus. Every copy sees the same lines on the same clock edge and applies the same rule, so all copies reach the same ownership decision without exchanging any other signal.

The agent identity is captured while reset is held and is frozen afterwards. While the bus is free, the lowest-numbered line that is pulled low wins on the next edge. The winner keeps the bus until the shared transaction-done pulse is seen, even if a higher-priority line goes low in the meantime. A free cycle follows every release, and then arbitration runs again. The local core receives a grant while its agent owns the bus. A registered bus-master indicator follows the grant for debug.

Top module: `mp_bus_arbiter`

## Requirements
- R1: The 8-bit request output `reqOutN` is all ones, except bit k, where k is the captured identity. Bit k is 0 while `coreReq` is 1 and reset is released.
- R2: `agentId` is sampled on every clock edge while `rstN` is low. Changes to it after reset is released have no effect on `reqOutN` or on arbitration.
- R3: After reset the bus is free and `grant` is 0. It stays free until at least one bit of `reqLinesN` is 0.
- R4: While the bus is free, the agent with the lowest index whose `reqLinesN` bit is 0 becomes owner at the next clock edge. All eight lines are considered, and a line driven by another agent makes that agent the owner.
- R5: `grant` is 1 exactly while the owner index equals the captured identity.
- R6: An owner keeps the bus on every edge where `xferDone` is 0, whatever the request lines do.
- R7: When `xferDone` is 1 while the bus is owned, the bus becomes free at that edge. Arbitration resumes at the following edge, so one free cycle separates two owners.
- R8: `xferDone` has no effect while the bus is free. If a line is low in that cycle, arbitration still happens.
- R9: `busMaster` equals the value `grant` had one clock earlier, and it is 0 in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, shared by all agents |
| rstN | input | 1 | Asynchronous active-low reset; identity is captured while low |
| agentId | input | 3 | Static identity of this agent |
| coreReq | input | 1 | Local core wants the bus |
| reqLinesN | input | 8 | Sampled shared request lines, active low |
| xferDone | input | 1 | Shared pulse marking the end of the owner's transaction |
| reqOutN | output | 8 | This agent's drive onto the request lines; only its own bit can be low |
| grant | output | 1 | This agent owns the bus |
| busMaster | output | 1 | Registered debug copy of ownership |

## Verification
The hardest case to reach is a higher-priority line going low while a lower-priority agent holds the bus. It has to show that ownership is held and then handed over only after a free cycle. The bench makes this agent the owner through its own fed-back line. It then pulls a lower-numbered line low and keeps it low across the release, so that it checks both the hold and the re-arbitration gap. A second reset with a different identity, together with identity changes during operation, shows that the identity is captured only in reset.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef struct packed {
    logic loadOwner;
    logic releaseOwner;
  } arbStrobes_t;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W = $clog2(NUM_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ID_W-1:0]       agentId,
  input  logic                  coreReq,
  input  logic [NUM_AGENTS-1:0] reqLinesN,
  input  arbStrobes_t           ctl,
  input  logic                  ownerValid,
  output logic                  anyReq,
  output logic                  selfOwns,
  output logic [ID_W-1:0]       idReg,
  output logic [NUM_AGENTS-1:0] reqOutN
);
  logic [ID_W-1:0] ownerId;
  logic [ID_W-1:0] winnerIdx;

  // identity follows the pins only while reset is held
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idReg <= agentId;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ownerId <= '0;
    else if (ctl.loadOwner) ownerId <= winnerIdx;
  end

  // lowest active index wins: scan downward so the last hit is the lowest
  always_comb begin
    winnerIdx = '0;
    for (int i = NUM_AGENTS - 1; i >= 0; i--) begin
      if (!reqLinesN[i]) winnerIdx = ID_W'(i);
    end
  end

  assign anyReq   = ~&reqLinesN;
  assign selfOwns = ownerValid && (ownerId == idReg);

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_reqDrive
    assign reqOutN[g] = !(rstN && coreReq && (idReg == ID_W'(g)));
  end
endmodule

// File: rtl/arb_control.sv
module arb_control
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        xferDone,
  input  logic        selfOwns,
  output arbStrobes_t ctl,
  output logic        ownerValid,
  output logic        busMaster
);
  typedef enum logic {ST_FREE, ST_OWNED} busState_t;
  busState_t state;

  always_comb begin
    ctl.loadOwner    = (state == ST_FREE) && anyReq;
    ctl.releaseOwner = (state == ST_OWNED) && xferDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FREE;
    else if (ctl.loadOwner) state <= ST_OWNED;
    else if (ctl.releaseOwner) state <= ST_FREE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busMaster <= 1'b0;
    else busMaster <= selfOwns;
  end

  assign ownerValid = (state == ST_OWNED);
endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_AGENTS = 8,
  localparam int ID_W = $clog2(NUM_AGENTS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ID_W-1:0]       agentId,
  input  logic                  coreReq,
  input  logic [NUM_AGENTS-1:0] reqLinesN,
  input  logic                  xferDone,
  output logic [NUM_AGENTS-1:0] reqOutN,
  output logic                  grant,
  output logic                  busMaster
);
  arbStrobes_t     ctl;
  logic            ownerValid;
  logic            anyReq;
  logic            selfOwns;
  logic [ID_W-1:0] idReg;

  arb_datapath #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .agentId(agentId), .coreReq(coreReq),
    .reqLinesN(reqLinesN), .ctl(ctl), .ownerValid(ownerValid),
    .anyReq(anyReq), .selfOwns(selfOwns), .idReg(idReg), .reqOutN(reqOutN)
  );

  arb_control u_ctl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .xferDone(xferDone),
    .selfOwns(selfOwns), .ctl(ctl), .ownerValid(ownerValid),
    .busMaster(busMaster)
  );

  assign grant = selfOwns;
endmodule

// File: rtl/mp_bus_arbiter_checker.sv
module mp_bus_arbiter_checker #(
  parameter int NUM_AGENTS = 8,
  parameter int ID_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_AGENTS-1:0] reqLinesN,
  input logic                  xferDone,
  input logic [NUM_AGENTS-1:0] reqOutN,
  input logic                  grant,
  input logic                  busMaster,
  input logic [ID_W-1:0]       idReg
);
  AST_ONE_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~reqOutN) <= 1); // R1
  AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $stable(idReg)); // R2
  AST_GRANT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(reqLinesN != '1)); // R3
  AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    grant && !xferDone |=> grant); // R6
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    grant && xferDone |=> !grant); // R7
  AST_MASTER_LAG: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> busMaster == $past(grant)); // R9
endmodule

bind mp_bus_arbiter mp_bus_arbiter_checker #(.NUM_AGENTS(NUM_AGENTS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqLinesN(reqLinesN), .xferDone(xferDone),
  .reqOutN(reqOutN), .grant(grant), .busMaster(busMaster), .idReg(idReg)
);

// File: tb/mp_bus_arbiter_bench.sv
module mp_bus_arbiter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] agentId = 3'd3;
  logic       coreReq = 1'b0;
  logic [7:0] othersN = 8'hFF;
  logic       xferDone = 1'b0;
  logic [7:0] reqOutN;
  logic [7:0] reqLinesN;
  logic       grant, busMaster;

  int checks = 0;
  int fails = 0;
  string curTag = "R3";

  // model state
  int  mValid = 0;
  int  mOwner = 0;
  int  mId = 3;
  bit  mBm = 1'b0;

  always #4 clk = ~clk;

  // shared lines: wired-AND of the other agents and this agent
  assign reqLinesN = othersN & reqOutN;

  mp_bus_arbiter u_mp_bus_arbiter (
    .clk(clk), .rstN(rstN), .agentId(agentId), .coreReq(coreReq),
    .reqLinesN(reqLinesN), .xferDone(xferDone), .reqOutN(reqOutN),
    .grant(grant), .busMaster(busMaster)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid = 0; mBm = 1'b0; mOwner = 0;
      mId = int'(agentId);
    end else begin
      mBm = (mValid == 1) && (mOwner == mId);
      if (mValid == 0) begin
        for (int i = 7; i >= 0; i--) if (!reqLinesN[i]) begin mValid = 1; mOwner = i; end
      end else if (xferDone) begin
        mValid = 0;
      end
    end
  end

  task automatic compareAll();
    logic [7:0] eReq;
    bit eGrant;
    eReq = 8'hFF;
    if (rstN && coreReq) eReq[mId] = 1'b0;
    eGrant = (mValid == 1) && (mOwner == mId);
    checks++;
    if (reqOutN !== eReq) begin
      fails++;
      $display("FAIL %s reqOutN actual %b expected %b", curTag, reqOutN, eReq);
    end
    checks++;
    if (grant !== eGrant) begin
      fails++;
      $display("FAIL %s grant actual %0b expected %0b", curTag, grant, eGrant);
    end
    checks++;
    if (busMaster !== mBm) begin
      fails++;
      $display("FAIL %s busMaster actual %0b expected %0b", curTag, busMaster, mBm);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    // R3: reset state and idle bus
    curTag = "R3";
    cycles(3);
    rstN = 1'b1;
    cycles(3);

    // R2: identity change after reset ignored
    curTag = "R2";
    agentId = 3'd5;
    cycles(2);

    // R1, R4, R5: own request on line 3 wins
    curTag = "R1";
    coreReq = 1'b1;
    cycles(1);
    curTag = "R5";
    cycles(2);

    // R6: higher-priority line 1 appears while owning
    curTag = "R6";
    othersN = 8'b1111_1101;
    cycles(3);

    // R7: release, gap cycle, then line 1 takes over
    curTag = "R7";
    coreReq = 1'b0;
    xferDone = 1'b1;
    cycles(1);
    xferDone = 1'b0;
    cycles(3);

    // R4: lines 1 and 6 low, line 1 keeps winning across a release
    curTag = "R4";
    othersN = 8'b1011_1101;
    xferDone = 1'b1;
    cycles(1);
    xferDone = 1'b0;
    cycles(3);

    // R4: own line 3 beats line 5
    othersN = 8'b1101_1111;
    coreReq = 1'b1;
    xferDone = 1'b1;
    cycles(1);
    xferDone = 1'b0;
    cycles(3);

    // R8: done while free has no effect, arbitration still happens
    curTag = "R8";
    othersN = 8'hFF;
    coreReq = 1'b0;
    xferDone = 1'b1;
    cycles(1);
    xferDone = 1'b1;
    cycles(2);
    othersN = 8'b1111_1110;
    cycles(2);
    xferDone = 1'b0;
    othersN = 8'hFF;
    cycles(2);

    // R9: busMaster lag is compared on every cycle above; R2 again with new reset id
    curTag = "R2";
    rstN = 1'b0;
    agentId = 3'd0;
    cycles(2);
    rstN = 1'b1;
    coreReq = 1'b1;
    cycles(3);
    curTag = "R9";
    agentId = 3'd7;
    xferDone = 1'b1;
    cycles(2);
    xferDone = 1'b0;
    coreReq = 1'b0;
    cycles(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule